// File: doc/BRIEF.md
# Multimode 16-bit Down-Counter / Timer

This block is a 16-bit down-counter loaded from a preset held as two separately written bytes. It runs in one of three modes. Timer mode gives a continuous square wave, suitable as a 16x baud clock for a serial receiver or transmitter. Counter mode gives a one-shot delay. Time-out mode is restarted by every received character and flags a pause in the incoming data. The counter only advances on cycles where `tick_en` is high, and `tick_en` is the one clock-source control the block has.

Commands are single-cycle pulses: start, stop, time-out mode on and off, preset byte writes and value byte reads. A sticky `ready` flag is raised each time the count passes through zero, and only the stop command clears it. The mode is chosen as follows: time-out mode takes precedence whenever it is on, and otherwise `timer_sel` picks timer (1) or counter (0). A mode change takes effect from the cycle after its command.

Top module: `cnt_timer16`

## Requirements
- R1: After reset the count, `ready`, `wave_out`, `rd_data`, both preset bytes and the time-out mode are all zero, and the counter is idle.
- R2: `wr_lo` writes `wr_data` into preset bits 7:0 and `wr_hi` writes it into bits 15:8. A load in the same cycle as a write uses the preset value from before that write.
- R3: `cmd_start` loads the preset into the count, starts counting and clears `wave_out`. `cmd_stop` freezes the count, halts the counter and clears both `ready` and `wave_out`.
- R4: A running counter decrements by one only on cycles with `tick_en` high and holds on all other cycles. Decrementing from 0x0000 gives 0xFFFF.
- R5: A terminal event sets `ready` one cycle later. In counter and time-out mode the terminal event is a tick that moves the count from 1 to 0. In timer mode it is a tick that finds the count at 1 or below. `ready` stays set until `cmd_stop`.
- R6: In timer mode a terminal event reloads the preset and toggles `wave_out`. Each half-period is therefore max(preset,1) ticks.
- R7: In counter mode a terminal event drives the count to 0 and sets `wave_out` high. The counter keeps running through 0xFFFF until stopped.
- R8: `tmo_on` and `tmo_off` set and clear time-out mode; `tmo_off` wins if both are asserted. In time-out mode `rx_char` reloads the preset and starts the count, and a terminal event sets `wave_out` and halts the counter at 0.
- R9: Outside time-out mode, `rx_char` has no effect on any output.
- R10: `rd_lo` returns count bits 7:0 on `rd_data` in the next cycle and latches all 16 bits. `rd_hi` returns bits 15:8 of that latch. `rd_lo` wins over `rd_hi`, and `rd_data` holds when neither is asserted.
- R11: Command priority is `cmd_stop` over `cmd_start` over `rx_char`. All of them take priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable for this cycle |
| timer_sel | input | 1 | 1 = timer mode, 0 = counter mode (when time-out mode is off) |
| cmd_start | input | 1 | Start pulse |
| cmd_stop | input | 1 | Stop pulse |
| tmo_on | input | 1 | Enter time-out mode |
| tmo_off | input | 1 | Leave time-out mode |
| rx_char | input | 1 | Character received pulse |
| wr_lo | input | 1 | Write preset low byte |
| wr_hi | input | 1 | Write preset high byte |
| wr_data | input | 8 | Preset byte data |
| rd_lo | input | 1 | Read low byte and latch value |
| rd_hi | input | 1 | Read latched high byte |
| rd_data | output | 8 | Read byte, valid the cycle after the strobe |
| cnt_value | output | 16 | Live count |
| wave_out | output | 1 | Square wave or terminal output |
| ready | output | 1 | Sticky zero-pass flag |

## Verification
A corrupted count shows up on `cnt_value` in the very next cycle, because the count is visible on every clock. A wrong mode or running state is less direct. It shows as a missed or extra reload on the next tick, or as a `wave_out` toggle or `ready` rise arriving one or more terminal events early or late. An error in the read latch stays hidden until the `rd_hi` that follows a `rd_lo`. The reference model is therefore compared on every cycle, so the first wrong cycle is the one reported.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

  typedef enum logic [1:0] {
    CTM_COUNTER = 2'd0,
    CTM_TIMER   = 2'd1,
    CTM_TIMEOUT = 2'd2
  } ctm_mode_e;

  // Time-out mode overrides the timer/counter select.
  function automatic ctm_mode_e ctm_pick_mode(input logic tmo, input logic timer);
    if (tmo)   return CTM_TIMEOUT;
    if (timer) return CTM_TIMER;
    return CTM_COUNTER;
  endfunction

endpackage

// File: rtl/ctm_preset.sv
module ctm_preset #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  localparam int CNT_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBYTES-1:0] wr_strobe,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  preset
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            byte_q <= '0;
      else if (wr_strobe[b]) byte_q <= wr_data;
    end

    assign preset[b*BYTE_W +: BYTE_W] = byte_q;

    AST_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe[b] |=> byte_q == $past(wr_data)); // R2
  end

endmodule

// File: rtl/ctm_core.sv
module ctm_core
  import ctm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             timer_sel,
  input  logic             start,
  input  logic             stop,
  input  logic             tmo_on,
  input  logic             tmo_off,
  input  logic             rx_char,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] cnt,
  output logic             ready,
  output logic             wave
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             running_q;
  logic             ready_q;
  logic             wave_q;
  logic             tmo_q;
  ctm_mode_e        mode_w;

  // Named internal events
  logic load_ev;
  logic step_ev;
  logic term_ev;

  function automatic logic at_terminal(input logic [CNT_W-1:0] c, input ctm_mode_e m);
    if (m == CTM_TIMER) return c <= ONE;
    return c == ONE;
  endfunction

  function automatic logic [CNT_W-1:0] step_value(input logic [CNT_W-1:0] c,
                                                  input ctm_mode_e m,
                                                  input logic [CNT_W-1:0] p);
    if (m == CTM_TIMER && at_terminal(c, m)) return p;
    return c - ONE;
  endfunction

  assign mode_w  = ctm_pick_mode(tmo_q, timer_sel);
  assign load_ev = !stop && (start || (tmo_q && rx_char));
  assign step_ev = !stop && !load_ev && running_q && tick_en;
  assign term_ev = step_ev && at_terminal(cnt_q, mode_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
      ready_q   <= 1'b0;
      wave_q    <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      if (tmo_off)     tmo_q <= 1'b0;
      else if (tmo_on) tmo_q <= 1'b1;

      if (stop) begin
        running_q <= 1'b0;
        ready_q   <= 1'b0;
        wave_q    <= 1'b0;
      end else if (load_ev) begin
        cnt_q     <= preset;
        running_q <= 1'b1;
        wave_q    <= 1'b0;
      end else if (step_ev) begin
        cnt_q <= step_value(cnt_q, mode_w, preset);
        if (term_ev) begin
          ready_q <= 1'b1;
          wave_q  <= (mode_w == CTM_TIMER) ? ~wave_q : 1'b1;
          if (mode_w == CTM_TIMEOUT) running_q <= 1'b0;
        end
      end
    end
  end

  assign cnt   = cnt_q;
  assign ready = ready_q;
  assign wave  = wave_q;

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!ready_q && !wave_q)); // R3
  AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> cnt_q == $past(preset)); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !term_ev) |=> cnt_q == CNT_W'($past(cnt_q) - ONE)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_ev) |=> $stable(cnt_q)); // R4
  AST_TERM_READY: assert property (@(posedge clk) disable iff (!rst_n)
    term_ev |=> ready_q); // R5
  AST_TIMER_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (term_ev && mode_w == CTM_TIMER) |=> wave_q != $past(wave_q)); // R6
  AST_COUNTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (term_ev && mode_w == CTM_COUNTER) |=> (cnt_q == '0 && wave_q && running_q)); // R7
  AST_TMO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (term_ev && mode_w == CTM_TIMEOUT) |=> (!running_q && cnt_q == '0)); // R8
  AST_RX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_char && !tmo_q && !start && !stop && !running_q) |=> $stable(cnt_q)); // R9
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && start) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/ctm_readback.sv
module ctm_readback #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic [CNT_W-1:0]  cnt,
  output logic [BYTE_W-1:0] rd_data
);

  logic [CNT_W-1:0]  snap_q;
  logic [BYTE_W-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      rd_q   <= '0;
    end else if (rd_lo) begin
      snap_q <= cnt;
      rd_q   <= cnt[BYTE_W-1:0];
    end else if (rd_hi) begin
      rd_q   <= snap_q[CNT_W-1:BYTE_W];
    end
  end

  assign rd_data = rd_q;

  AST_LO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> rd_data == $past(cnt[BYTE_W-1:0])); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lo && !rd_hi) |=> $stable(rd_data)); // R10

endmodule

// File: rtl/cnt_timer16.sv
module cnt_timer16 #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              timer_sel,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              tmo_on,
  input  logic              tmo_off,
  input  logic              rx_char,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CNT_W-1:0]  cnt_value,
  output logic              wave_out,
  output logic              ready
);

  logic [CNT_W-1:0] preset_w;
  logic [CNT_W-1:0] cnt_w;

  ctm_preset #(.BYTE_W(BYTE_W), .NBYTES(2)) u_preset (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_strobe ({wr_hi, wr_lo}),
    .wr_data   (wr_data),
    .preset    (preset_w)
  );

  ctm_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .timer_sel (timer_sel),
    .start     (cmd_start),
    .stop      (cmd_stop),
    .tmo_on    (tmo_on),
    .tmo_off   (tmo_off),
    .rx_char   (rx_char),
    .preset    (preset_w),
    .cnt       (cnt_w),
    .ready     (ready),
    .wave      (wave_out)
  );

  ctm_readback #(.BYTE_W(BYTE_W)) u_read (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_lo   (rd_lo),
    .rd_hi   (rd_hi),
    .cnt     (cnt_w),
    .rd_data (rd_data)
  );

  assign cnt_value = cnt_w;

endmodule

// File: tb/cnt_timer16_tb_top.sv
`timescale 1ns/1ps
module cnt_timer16_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, timer_sel = 1'b0, cmd_start = 1'b0, cmd_stop = 1'b0;
  logic tmo_on = 1'b0, tmo_off = 1'b0, rx_char = 1'b0;
  logic wr_lo = 1'b0, wr_hi = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic [15:0] cnt_value;
  logic        wave_out, ready;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  cnt_timer16 dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .timer_sel(timer_sel),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .tmo_on(tmo_on), .tmo_off(tmo_off),
    .rx_char(rx_char), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data), .cnt_value(cnt_value),
    .wave_out(wave_out), .ready(ready)
  );

  // Behavioural reference model built from the requirements
  int m_cnt, m_pre, m_snap, m_rd, m_md;
  bit m_run, m_rdy, m_wave, m_tmo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_snap = 0; m_rd = 0;
      m_run = 0; m_rdy = 0; m_wave = 0; m_tmo = 0;
    end else begin
      if (rd_lo) begin m_snap = m_cnt; m_rd = m_cnt % 256; end    // R10
      else if (rd_hi) m_rd = m_snap / 256;
      m_md = m_tmo ? 2 : (timer_sel ? 1 : 0);
      if (cmd_stop) begin m_run = 0; m_rdy = 0; m_wave = 0; end   // R3, R11
      else if (cmd_start || (m_tmo && rx_char)) begin             // R8, R11
        m_cnt = m_pre; m_run = 1; m_wave = 0;
      end else if (m_run && tick_en) begin                         // R4
        if (m_md == 1) begin                                       // R6
          if (m_cnt <= 1) begin m_cnt = m_pre; m_wave = !m_wave; m_rdy = 1; end
          else m_cnt = m_cnt - 1;
        end else begin                                             // R7, R8
          if (m_cnt == 1) begin m_rdy = 1; m_wave = 1; if (m_md == 2) m_run = 0; end
          m_cnt = (m_cnt + 65535) % 65536;
        end
      end
      if (wr_lo) m_pre = (m_pre / 256) * 256 + wr_data;            // R2
      if (wr_hi) m_pre = (m_pre % 256) + wr_data * 256;
      if (tmo_off) m_tmo = 0; else if (tmo_on) m_tmo = 1;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("cnt_value", cnt_value, m_cnt);
      chk("ready", ready, m_rdy);
      chk("wave_out", wave_out, m_wave);
      chk("rd_data", rd_data, m_rd);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_preset(input int v);
    wr_data = v[7:0]; wr_lo = 1; @(negedge clk); wr_lo = 0;
    wr_data = v[15:8]; wr_hi = 1; @(negedge clk); wr_hi = 0;
  endtask

  task automatic pulse_start(); cmd_start = 1; @(negedge clk); cmd_start = 0; endtask
  task automatic pulse_stop();  cmd_stop = 1;  @(negedge clk); cmd_stop = 0;  endtask
  task automatic pulse_rx();    rx_char = 1;   @(negedge clk); rx_char = 0;   endtask

  task automatic read_both();
    rd_lo = 1; @(negedge clk); rd_lo = 0;
    cyc(3);
    rd_hi = 1; @(negedge clk); rd_hi = 0;
  endtask

  initial begin
    cyc(3);
    cur_req = "R1";
    chk("reset cnt_value", cnt_value, 0);
    chk("reset ready", ready, 0);
    chk("reset wave_out", wave_out, 0);
    chk("reset rd_data", rd_data, 0);
    rst_n = 1;
    cmp_on = 1;
    cyc(2);

    // R7 counter mode, R5 ready
    cur_req = "R7"; tick_en = 1; timer_sel = 0;
    wr_preset(16'h0005);
    pulse_start(); cyc(12);
    cur_req = "R10"; read_both(); cyc(2);
    cur_req = "R3"; pulse_stop(); cyc(5);

    // R6 timer mode
    cur_req = "R6"; timer_sel = 1;
    wr_preset(16'h0003); pulse_start(); cyc(30);
    wr_preset(16'h0000); cyc(12);
    wr_preset(16'h0001); cyc(8);
    cur_req = "R3"; pulse_stop(); cyc(3);

    // R4 gated ticks and wrap
    cur_req = "R4"; timer_sel = 0;
    wr_preset(16'h0102); pulse_start();
    for (int i = 0; i < 400; i++) begin
      tick_en = ($urandom % 3) != 0;
      @(negedge clk);
    end
    tick_en = 1;
    cur_req = "R5"; cyc(300);
    cur_req = "R10"; read_both(); rd_lo = 1; rd_hi = 1; @(negedge clk); rd_lo = 0; rd_hi = 0; cyc(2);
    cur_req = "R3"; pulse_stop(); cyc(3);

    // R2 write and start in the same cycle
    cur_req = "R2";
    wr_data = 8'h09; wr_lo = 1; cmd_start = 1; @(negedge clk);
    wr_lo = 0; cmd_start = 0; cyc(15);

    // R9 rx ignored outside time-out mode
    cur_req = "R9"; pulse_stop(); pulse_rx(); cyc(2); pulse_rx(); cyc(3);

    // R11 stop beats start
    cur_req = "R11"; cmd_start = 1; cmd_stop = 1; @(negedge clk);
    cmd_start = 0; cmd_stop = 0; cyc(3);

    // R8 time-out mode
    cur_req = "R8";
    tmo_on = 1; @(negedge clk); tmo_on = 0;
    wr_preset(16'h0006);
    pulse_rx(); cyc(3); pulse_rx(); cyc(4); pulse_rx(); cyc(12);
    pulse_rx(); cyc(2);
    cur_req = "R11"; cmd_start = 1; rx_char = 1; @(negedge clk); cmd_start = 0; rx_char = 0;
    cmd_stop = 1; rx_char = 1; @(negedge clk); cmd_stop = 0; rx_char = 0; cyc(4);
    cur_req = "R8"; tmo_on = 1; tmo_off = 1; @(negedge clk); tmo_on = 0; tmo_off = 0;
    cur_req = "R9"; pulse_rx(); cyc(4);
    cur_req = "R8"; tmo_on = 1; @(negedge clk); tmo_on = 0; pulse_rx(); cyc(10);
    tmo_off = 1; @(negedge clk); tmo_off = 0; cyc(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule